// File: doc/BRIEF.md
# Dual-Clock System Clock Controller

This block decides where a microcontroller's system clock and LCD clock come from, and which oscillators are allowed to run. The oscillators are outside the block. Each one delivers a one-cycle tick enable on the fabric clock, and the block passes the selected ticks on as the system tick and the LCD tick. A static strap fixes the part in dual-clock mode or single-clock mode. In dual-clock mode a 32768 Hz sub-clock is available besides the main clock. In single-clock mode only the main clock exists.

Software writes two control bits. One chooses slow operation, where the system runs from the sub-clock. The other switches the main oscillator off. A change of source takes effect on the first tick of the new source. No tick from the old source is sent out while the change is pending. A STOP request halts both oscillators. It is refused while the LCD is still enabled. A wake-up input ends STOP and lets both oscillators run again.

There is no data stream here, so there is no valid/ready handshake. Every pin is a plain level or a one-cycle strobe.

Top module: `clkctl_top`

## Requirements
- R1: After reset, slow select, main-off and STOP all read 0, the active source is the main clock (`src_o` = 0), `err_o` is 0 and `main_osc_en_o` is 1. `sub_osc_en_o` is 1 when the strap selects dual-clock mode.
- R2: In single-clock mode (`dual_mode_i` = 0), `slow_sel_o` and `main_off_o` stay 0 whatever is written, `sub_osc_en_o` is 0, and such a write raises no error.
- R3: In dual-clock mode, once a switch has completed, `sys_tick_o` follows the sub tick when slow select is 1 and the main tick when it is 0. Ticks of the other source are not passed on.
- R4: After slow select changes, no tick of the old source reaches `sys_tick_o`. The first tick of the new source is passed on in the same cycle, and `src_o` shows the new source from the next cycle on.
- R5: In dual-clock mode, a write that sets main-off to 1 together with slow select 0 is rejected as a whole, and both control bits keep their values.
- R6: In dual-clock mode, a write of slow select 1 and main-off 1 is accepted and drops `main_osc_en_o` to 0 from the next cycle.
- R7: A STOP request while `lcd_on_i` is 0 sets `stop_o` from the next cycle. While stopped, both oscillator enables are 0 and neither `sys_tick_o` nor `lcd_tick_o` pulses.
- R8: A STOP request while `lcd_on_i` is 1 is ignored, and `stop_o` keeps its value.
- R9: A wake-up pulse clears STOP and main-off from the next cycle, so both oscillator enables return. A wake-up takes priority over a STOP request in the same cycle.
- R10: In dual-clock mode, `lcd_tick_o` pulses exactly on enabled sub ticks.
- R11: In single-clock mode, `lcd_tick_o` pulses on every 128th enabled main tick (parameter `LCD_DIV`), first on the 128th tick after reset.
- R12: A rejected write (R5) or a rejected STOP (R8) gives a one-cycle `err_o` pulse in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_mode_i | input | 1 | Strap: 1 = dual-clock mode, 0 = single-clock mode |
| main_tick_i | input | 1 | Tick enable from the main oscillator |
| sub_tick_i | input | 1 | Tick enable from the sub-oscillator |
| cfg_we_i | input | 1 | Write strobe for the control bits |
| cfg_slow_i | input | 1 | Written value of slow select |
| cfg_main_off_i | input | 1 | Written value of main-off |
| stop_req_i | input | 1 | STOP request strobe |
| wake_i | input | 1 | Wake-up strobe |
| lcd_on_i | input | 1 | LCD enabled level |
| sys_tick_o | output | 1 | Selected system tick |
| lcd_tick_o | output | 1 | LCD tick |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub-oscillator enable |
| slow_sel_o | output | 1 | Current slow select bit |
| main_off_o | output | 1 | Current main-off bit |
| src_o | output | 1 | Active source: 0 = main, 1 = sub |
| stop_o | output | 1 | STOP state |
| err_o | output | 1 | Rejection pulse |

## Verification
The assertions assume that `dual_mode_i` is held steady for as long as reset is released, and that the tick inputs are single-cycle enables. The bench sets the strap only while reset is applied, and it drives every strobe and tick for exactly one cycle, away from the clock edge. The assertions also assume that a STOP request and a wake-up may arrive together. Directed tests cover that case only through the defined priority, in which wake-up wins.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_SUB  = 1'b1
  } src_e;
endpackage

// File: rtl/clkctl_cfg.sv
// Control bits, write validation, STOP state and rejection pulse.
module clkctl_cfg
  import clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dual_i,
  input  logic we_i,
  input  logic slow_i,
  input  logic off_i,
  input  logic stop_req_i,
  input  logic wake_i,
  input  logic lcd_on_i,
  output src_e sel_o,
  output logic off_o,
  output logic stop_o,
  output logic err_o
);
  src_e sel_q;
  logic off_q, stop_q, err_q;
  logic wr_bad, stop_bad;

  // Turning main off while main is still selected would starve the system.
  assign wr_bad   = dual_i && we_i && off_i && !slow_i;
  // STOP with the LCD still enabled is refused.
  assign stop_bad = stop_req_i && lcd_on_i && !wake_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_MAIN;
      off_q <= 1'b0;
    end else if (!dual_i) begin
      sel_q <= SRC_MAIN;
      off_q <= 1'b0;
    end else begin
      if (we_i && !wr_bad) begin
        sel_q <= slow_i ? SRC_SUB : SRC_MAIN;
        off_q <= off_i;
      end
      if (wake_i) off_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wake_i)                        stop_q <= 1'b0;
      else if (stop_req_i && !lcd_on_i)  stop_q <= 1'b1;
      err_q <= wr_bad || stop_bad;
    end
  end

  assign sel_o  = sel_q;
  assign off_o  = off_q;
  assign stop_o = stop_q;
  assign err_o  = err_q;
endmodule

// File: rtl/clkctl_mux.sv
// Source switch: a change completes on the first tick of the new source.
module clkctl_mux
  import clkctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e want_i,
  input  logic main_t_i,
  input  logic sub_t_i,
  output logic tick_o,
  output src_e src_o
);
  src_e cur_q;
  logic cur_t, new_t, pend;

  assign cur_t  = (cur_q  == SRC_SUB) ? sub_t_i : main_t_i;
  assign new_t  = (want_i == SRC_SUB) ? sub_t_i : main_t_i;
  assign pend   = (want_i != cur_q);
  assign tick_o = pend ? new_t : cur_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cur_q <= SRC_MAIN;
    else if (pend && new_t) cur_q <= want_i;
  end

  assign src_o = cur_q;
endmodule

// File: rtl/clkctl_lcd.sv
// LCD tick source: sub tick in dual mode, main tick divided by DIV otherwise.
module clkctl_lcd #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_i,
  input  logic main_t_i,
  input  logic sub_t_i,
  output logic lcd_t_o
);
  logic div_t;

  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      logic          hit;

      assign hit = main_t_i && (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!dual_i && main_t_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end

      assign div_t = hit;
    end else begin : g_pass
      assign div_t = main_t_i;
    end
  endgenerate

  assign lcd_t_o = dual_i ? sub_t_i : div_t;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned LCD_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_mode_i,
  input  logic main_tick_i,
  input  logic sub_tick_i,
  input  logic cfg_we_i,
  input  logic cfg_slow_i,
  input  logic cfg_main_off_i,
  input  logic stop_req_i,
  input  logic wake_i,
  input  logic lcd_on_i,
  output logic sys_tick_o,
  output logic lcd_tick_o,
  output logic main_osc_en_o,
  output logic sub_osc_en_o,
  output logic slow_sel_o,
  output logic main_off_o,
  output logic src_o,
  output logic stop_o,
  output logic err_o
);
  src_e sel, src;
  logic off, stopped, main_en, sub_en, main_g, sub_g;

  clkctl_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_i     (dual_mode_i),
    .we_i       (cfg_we_i),
    .slow_i     (cfg_slow_i),
    .off_i      (cfg_main_off_i),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_i),
    .lcd_on_i   (lcd_on_i),
    .sel_o      (sel),
    .off_o      (off),
    .stop_o     (stopped),
    .err_o      (err_o)
  );

  // Oscillator enables; ticks of a disabled oscillator are discarded.
  assign main_en = !stopped && !off;
  assign sub_en  = dual_mode_i && !stopped;
  assign main_g  = main_tick_i && main_en;
  assign sub_g   = sub_tick_i && sub_en;

  clkctl_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_i   (sel),
    .main_t_i (main_g),
    .sub_t_i  (sub_g),
    .tick_o   (sys_tick_o),
    .src_o    (src)
  );

  clkctl_lcd #(.DIV(LCD_DIV)) u_lcd (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual_i   (dual_mode_i),
    .main_t_i (main_g),
    .sub_t_i  (sub_g),
    .lcd_t_o  (lcd_tick_o)
  );

  assign main_osc_en_o = main_en;
  assign sub_osc_en_o  = sub_en;
  assign slow_sel_o    = (sel == SRC_SUB);
  assign main_off_o    = off;
  assign src_o         = (src == SRC_SUB);
  assign stop_o        = stopped;
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
  input logic clk,
  input logic rst_n,
  input logic dual_mode_i,
  input logic main_tick_i,
  input logic sub_tick_i,
  input logic cfg_we_i,
  input logic cfg_slow_i,
  input logic cfg_main_off_i,
  input logic stop_req_i,
  input logic wake_i,
  input logic lcd_on_i,
  input logic sys_tick_o,
  input logic lcd_tick_o,
  input logic main_osc_en_o,
  input logic sub_osc_en_o,
  input logic slow_sel_o,
  input logic main_off_o,
  input logic src_o,
  input logic stop_o,
  input logic err_o
);
  p_single_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode_i |-> (!slow_sel_o && !main_off_o && !sub_osc_en_o));

  p_tick_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_tick_o |-> ((main_tick_i && main_osc_en_o) || (sub_tick_i && sub_osc_en_o)));

  p_switch_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick_o && (slow_sel_o != src_o)) |=> (src_o == $past(slow_sel_o)));

  p_no_old_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_tick_o && slow_sel_o && !src_o) |-> (sub_tick_i && !main_off_o || sub_tick_i));

  p_reject_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode_i && cfg_we_i && cfg_main_off_i && !cfg_slow_i && !wake_i)
      |=> (err_o && $stable(main_off_o) && $stable(slow_sel_o)));

  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!main_osc_en_o && !sub_osc_en_o && !sys_tick_o && !lcd_tick_o));

  p_stop_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req_i && lcd_on_i && !wake_i) |=> (err_o && $stable(stop_o)));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (!stop_o && main_osc_en_o && !main_off_o));

  p_lcd_dual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode_i && lcd_tick_o) |-> sub_tick_i);
endmodule

bind clkctl_top clkctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dual_mode_i(dual_mode_i),
  .main_tick_i(main_tick_i), .sub_tick_i(sub_tick_i),
  .cfg_we_i(cfg_we_i), .cfg_slow_i(cfg_slow_i), .cfg_main_off_i(cfg_main_off_i),
  .stop_req_i(stop_req_i), .wake_i(wake_i), .lcd_on_i(lcd_on_i),
  .sys_tick_o(sys_tick_o), .lcd_tick_o(lcd_tick_o),
  .main_osc_en_o(main_osc_en_o), .sub_osc_en_o(sub_osc_en_o),
  .slow_sel_o(slow_sel_o), .main_off_o(main_off_o), .src_o(src_o),
  .stop_o(stop_o), .err_o(err_o)
);

// File: tb/tb_clkctl_top.sv
`timescale 1ns/1ps
module tb_clkctl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode_i = 1'b1;
  logic main_tick_i = 1'b0, sub_tick_i = 1'b0;
  logic cfg_we_i = 1'b0, cfg_slow_i = 1'b0, cfg_main_off_i = 1'b0;
  logic stop_req_i = 1'b0, wake_i = 1'b0, lcd_on_i = 1'b0;
  logic sys_tick_o, lcd_tick_o, main_osc_en_o, sub_osc_en_o;
  logic slow_sel_o, main_off_o, src_o, stop_o, err_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  clkctl_top dut (.*);

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle: set ticks, clear strobes, let combinational outputs settle.
  task automatic cyc(input logic m, input logic s);
    @(posedge clk); #1;
    main_tick_i = m; sub_tick_i = s;
    cfg_we_i = 0; stop_req_i = 0; wake_i = 0;
    #1;
  endtask

  task automatic wr(input logic slow, input logic off);
    @(posedge clk); #1;
    main_tick_i = 0; sub_tick_i = 0; stop_req_i = 0; wake_i = 0;
    cfg_we_i = 1; cfg_slow_i = slow; cfg_main_off_i = off;
    #1;
  endtask

  task automatic strobe(input logic stp, input logic wk);
    @(posedge clk); #1;
    main_tick_i = 0; sub_tick_i = 0; cfg_we_i = 0;
    stop_req_i = stp; wake_i = wk;
    #1;
  endtask

  task automatic do_reset(input logic dual);
    rst_n = 0; dual_mode_i = dual; lcd_on_i = 0;
    main_tick_i = 0; sub_tick_i = 0; cfg_we_i = 0; stop_req_i = 0; wake_i = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    #1;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check("R1 slow", slow_sel_o, 0);
    check("R1 off", main_off_o, 0);
    check("R1 stop", stop_o, 0);
    check("R1 src", src_o, 0);
    check("R1 err", err_o, 0);
    check("R1 main_en", main_osc_en_o, 1);
    check("R1 sub_en", sub_osc_en_o, 1);
  endtask

  task automatic t_switch();
    do_reset(1'b1);
    cyc(1, 0); check("R3 main tick passes", sys_tick_o, 1);
    cyc(0, 1); check("R3 sub tick blocked", sys_tick_o, 0);
    wr(1, 0);
    cyc(0, 0); check("R4 sel set", slow_sel_o, 1);
    check("R4 src pending", src_o, 0);
    cyc(1, 0); check("R4 old tick dropped", sys_tick_o, 0);
    cyc(0, 1); check("R4 first new tick", sys_tick_o, 1);
    check("R4 src before edge", src_o, 0);
    cyc(0, 0); check("R4 src switched", src_o, 1);
    cyc(1, 0); check("R3 main blocked in slow", sys_tick_o, 0);
    cyc(0, 1); check("R3 sub passes in slow", sys_tick_o, 1);
  endtask

  task automatic t_main_off();
    do_reset(1'b1);
    wr(0, 1);
    cyc(0, 0); check("R12 err after bad write", err_o, 1);
    check("R5 off kept", main_off_o, 0);
    check("R5 main_en kept", main_osc_en_o, 1);
    cyc(0, 0); check("R12 err one cycle", err_o, 0);
    wr(1, 1);
    cyc(0, 0); check("R6 main_en low", main_osc_en_o, 0);
    check("R6 off set", main_off_o, 1);
    check("R6 no err", err_o, 0);
    cyc(1, 0); check("R6 main tick gated", sys_tick_o, 0);
    cyc(0, 1); check("R6 sub tick passes", sys_tick_o, 1);
  endtask

  task automatic t_stop();
    do_reset(1'b1);
    wr(1, 1);
    cyc(0, 1);
    lcd_on_i = 1;
    strobe(1, 0);
    cyc(0, 0); check("R8 stop refused", stop_o, 0);
    check("R12 err after refused stop", err_o, 1);
    cyc(0, 1); check("R8 still ticking", sys_tick_o, 1);
    lcd_on_i = 0;
    strobe(1, 0);
    cyc(1, 1); check("R7 stopped", stop_o, 1);
    check("R7 no sys tick", sys_tick_o, 0);
    check("R7 no lcd tick", lcd_tick_o, 0);
    check("R7 main_en", main_osc_en_o, 0);
    check("R7 sub_en", sub_osc_en_o, 0);
    strobe(1, 1);
    cyc(0, 0); check("R9 wake wins", stop_o, 0);
    check("R9 main_en", main_osc_en_o, 1);
    check("R9 sub_en", sub_osc_en_o, 1);
    check("R9 off cleared", main_off_o, 0);
  endtask

  task automatic t_lcd_dual();
    do_reset(1'b1);
    cyc(0, 1); check("R10 lcd on sub", lcd_tick_o, 1);
    cyc(1, 0); check("R10 lcd not on main", lcd_tick_o, 0);
  endtask

  task automatic t_single();
    int early;
    do_reset(1'b0);
    check("R2 sub_en", sub_osc_en_o, 0);
    wr(1, 1);
    cyc(0, 0); check("R2 slow forced", slow_sel_o, 0);
    check("R2 off forced", main_off_o, 0);
    check("R2 no err", err_o, 0);
    cyc(0, 1); check("R2 sub tick ignored", sys_tick_o, 0);
    early = 0;
    for (int i = 0; i < 127; i++) begin
      cyc(1, 0);
      if (lcd_tick_o) early++;
    end
    check("R11 no lcd before 128", early != 0, 0);
    check("R2 main passes", sys_tick_o, 1);
    cyc(1, 0); check("R11 lcd on 128th", lcd_tick_o, 1);
    cyc(1, 0); check("R11 lcd after wrap", lcd_tick_o, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_switch();
    t_main_off();
    t_stop();
    t_lcd_dual();
    t_single();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule